// File: doc/BRIEF.md
# Serial Control Bus Slave with Command-Implied Framing

This block is the receiving end of a byte-wide serial control link with three inbound wires (serial clock, command data and an active-low chip select) and one reply wire that is enabled only while it carries data. A host lowers chip select and clocks in an address/command byte, most significant bit first. The value of that byte alone decides what follows. It can be nothing (the clear command), one or two write bytes, or one reply byte that the slave shifts out. Raising chip select ends the transfer. If it is raised early, the partial transfer has no effect.

Writes go to a register file of eight 8-bit and four 16-bit control registers. The whole file is presented as one flat output vector for the logic that uses it. Reads return one of two status bytes supplied from outside the block. All three bus inputs pass through a synchroniser and are edge-detected against a fast system clock. Command data is sampled on the rising serial-clock edge, and reply data changes after the falling edge.

Top module: `sbus_slave`

## Requirements
- R1: After system reset, `regs_flat` is all zero and `bus_reply_oe` is 0.
- R2: A frame holding command $80, $82, $85, $86, $87, $88, $8B or $8E followed by one byte (MSB first) stores that byte in flat slice 0, 1, 2, 3, 4, 5, 6 or 7 respectively, where slice n is `regs_flat[8n+7:8n]`.
- R3: A frame holding command $83, $84, $8A or $8D followed by two bytes stores {first byte, second byte} in 16-bit slice 0, 1, 2 or 3 respectively, where slice n is `regs_flat[64+16n+15:64+16n]`.
- R4: A 16-bit register is unchanged when chip select rises after its first data byte but before its second byte is complete.
- R5: A frame ended before its command byte or its final data byte is complete changes no register.
- R6: Command $01 is a complete frame by itself and sets every register to zero.
- R7: Bits 4, 3 and 1 of the register at $80 (flat bits 4, 3, 1) are always stored as 0, whatever value is written.
- R8: A command byte with no assigned meaning (for example $9C or $C3), together with any bytes that follow it, changes no register.
- R9: Command $81 returns `status_byte` and command $8F returns `flag_byte`, captured when the command byte completes. The reply is sent MSB first, each bit presented after a serial-clock falling edge and valid at the next rising edge.
- R10: `bus_reply_oe` is 1 only from the falling edge after a read command byte until the falling edge after the eighth reply bit, or until chip select rises, whichever comes first.
- R11: A serial-clock rising edge seen in the same synchronised cycle as chip select rising is not counted, so a byte it would have completed is discarded.
- R12: Bytes clocked in after the last byte that a command expects, in the same frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sclk | input | 1 | Serial clock from the host |
| bus_csn | input | 1 | Active-low chip select framing each transfer |
| bus_cmd | input | 1 | Serial command and write data, MSB first |
| bus_reply | output | 1 | Serial reply data |
| bus_reply_oe | output | 1 | Drive enable for the reply pin; high impedance when 0 |
| status_byte | input | 8 | Byte returned by command $81 |
| flag_byte | input | 8 | Byte returned by command $8F |
| regs_flat | output | 128 | All control registers, packed as given in R2 and R3 |

## Verification
The one real collision is chip select rising in the same synchronised cycle as the serial-clock edge that would complete the final byte of a write. Both signals pass through identical synchronisers, so the bench raises them at the same instant and expects the target register to keep its old value. Before and after that case, ordinary writes to the same address show that the path works and that the next frame starts clean. Aborts at other points (after the first half of a 16-bit write, in the middle of a byte, inside a clear command) are judged the same way, by reading the register image after the frame.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   localparam int BYTE_W   = 8;
   localparam int N_NARROW = 8;
   localparam int N_WIDE   = 4;
   localparam int NIDX_W   = $clog2(N_NARROW);
   localparam int WIDX_W   = $clog2(N_WIDE);
   localparam int FLAT_W   = N_NARROW*BYTE_W + N_WIDE*2*BYTE_W;

   localparam logic [BYTE_W-1:0] CMD_CLEAR   = 8'h01;
   localparam logic [BYTE_W-1:0] RD_STATUS   = 8'h81;
   localparam logic [BYTE_W-1:0] RD_FLAGS    = 8'h8F;
   localparam logic [BYTE_W-1:0] ADDR_SIGCTL = 8'h80;
   localparam logic [BYTE_W-1:0] SIGCTL_KEEP = 8'hE5;

   typedef enum logic [2:0] {K_IGNORE, K_CLEAR, K_NARROW, K_WIDE, K_REPLY} cmd_kind_e;
   typedef enum logic [2:0] {S_CMD, S_DATA1, S_DATA2, S_REPLY, S_DONE} frame_st_e;

   function automatic cmd_kind_e kind_of(input logic [BYTE_W-1:0] c);
      case (c)
         8'h01:                                           return K_CLEAR;
         8'h80, 8'h82, 8'h85, 8'h86, 8'h87, 8'h88,
         8'h8B, 8'h8E:                                    return K_NARROW;
         8'h83, 8'h84, 8'h8A, 8'h8D:                      return K_WIDE;
         8'h81, 8'h8F:                                    return K_REPLY;
         default:                                         return K_IGNORE;
      endcase
   endfunction

   function automatic logic [NIDX_W-1:0] narrow_slot(input logic [BYTE_W-1:0] c);
      case (c)
         8'h82:   return 3'd1;
         8'h85:   return 3'd2;
         8'h86:   return 3'd3;
         8'h87:   return 3'd4;
         8'h88:   return 3'd5;
         8'h8B:   return 3'd6;
         8'h8E:   return 3'd7;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [WIDX_W-1:0] wide_slot(input logic [BYTE_W-1:0] c);
      case (c)
         8'h84:   return 2'd1;
         8'h8A:   return 2'd2;
         8'h8D:   return 2'd3;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sbus_frame.sv
module sbus_frame
   import sbus_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_s,
   input  logic                  csn_s,
   input  logic                  din_s,
   input  logic [BYTE_W-1:0]     stat_i,
   input  logic [BYTE_W-1:0]     flag_i,
   output logic                  wr_en_o,
   output logic                  wr_wide_o,
   output logic [BYTE_W-1:0]     wr_addr_o,
   output logic [2*BYTE_W-1:0]   wr_data_o,
   output logic                  clr_o,
   output logic                  fall_o,
   output logic                  reply_o,
   output logic                  reply_oe_o
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W-1);

   frame_st_e          st;
   logic [CNT_W-1:0]   cnt;
   logic [BYTE_W-1:0]  sh, hi, cmd_q, rsh;
   logic               sclk_d, rise, byte_end, wr_narrow, wr_wide;
   logic [BYTE_W-1:0]  byte_nx;

   assign rise     = sclk_s & ~sclk_d & ~csn_s;
   assign fall_o   = ~sclk_s & sclk_d & ~csn_s;
   assign byte_nx  = {sh[BYTE_W-2:0], din_s};
   assign byte_end = rise && (cnt == LAST_BIT);

   assign clr_o     = byte_end && (st == S_CMD) && (kind_of(byte_nx) == K_CLEAR);
   assign wr_narrow = byte_end && (st == S_DATA1) && (kind_of(cmd_q) == K_NARROW);
   assign wr_wide   = byte_end && (st == S_DATA2);
   assign wr_en_o   = wr_narrow | wr_wide;
   assign wr_wide_o = wr_wide;
   assign wr_addr_o = cmd_q;
   assign wr_data_o = wr_wide ? {hi, byte_nx} : {{BYTE_W{1'b0}}, byte_nx};

   always_ff @(posedge clk) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_CMD;
         cnt        <= '0;
         sh         <= '0;
         hi         <= '0;
         cmd_q      <= '0;
         rsh        <= '0;
         reply_o    <= 1'b0;
         reply_oe_o <= 1'b0;
      end else if (csn_s) begin
         st         <= S_CMD;
         cnt        <= '0;
         reply_oe_o <= 1'b0;
      end else if (rise) begin
         sh  <= byte_nx;
         cnt <= cnt + CNT_W'(1);
         if (cnt == LAST_BIT) begin
            case (st)
               S_CMD: begin
                  cmd_q <= byte_nx;
                  case (kind_of(byte_nx))
                     K_CLEAR: st <= S_DONE;
                     K_REPLY: begin
                        st  <= S_REPLY;
                        rsh <= (byte_nx == RD_STATUS) ? stat_i : flag_i;
                     end
                     default: st <= S_DATA1;
                  endcase
               end
               S_DATA1: begin
                  if (kind_of(cmd_q) == K_WIDE) begin
                     hi <= byte_nx;
                     st <= S_DATA2;
                  end else begin
                     st <= S_DONE;
                  end
               end
               S_DATA2: st <= S_DONE;
               S_REPLY: st <= S_DONE;
               default: st <= S_DONE;
            endcase
         end
      end else if (fall_o) begin
         if (st == S_REPLY) begin
            reply_o    <= rsh[BYTE_W-1];
            rsh        <= {rsh[BYTE_W-2:0], 1'b0};
            reply_oe_o <= 1'b1;
         end else begin
            reply_oe_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
   import sbus_pkg::*;
#(
   parameter bit RSVD_ZERO = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 wr_en_i,
   input  logic                 wr_wide_i,
   input  logic [BYTE_W-1:0]    wr_addr_i,
   input  logic [2*BYTE_W-1:0]  wr_data_i,
   output logic [FLAT_W-1:0]    flat_o
);
   localparam int WIDE_BASE = N_NARROW*BYTE_W;

   logic [BYTE_W-1:0]   nar [N_NARROW];
   logic [2*BYTE_W-1:0] wid [N_WIDE];
   logic [BYTE_W-1:0]   sigctl_keep;

   if (RSVD_ZERO) begin : g_mask
      assign sigctl_keep = SIGCTL_KEEP;
   end else begin : g_nomask
      assign sigctl_keep = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         for (int i = 0; i < N_NARROW; i++) nar[i] <= '0;
         for (int i = 0; i < N_WIDE; i++)   wid[i] <= '0;
      end else if (wr_en_i) begin
         if (wr_wide_i)
            wid[wide_slot(wr_addr_i)] <= wr_data_i;
         else if (wr_addr_i == ADDR_SIGCTL)
            nar[narrow_slot(wr_addr_i)] <= wr_data_i[BYTE_W-1:0] & sigctl_keep;
         else
            nar[narrow_slot(wr_addr_i)] <= wr_data_i[BYTE_W-1:0];
      end
   end

   for (genvar g = 0; g < N_NARROW; g++) begin : g_pack_n
      assign flat_o[g*BYTE_W +: BYTE_W] = nar[g];
   end
   for (genvar g = 0; g < N_WIDE; g++) begin : g_pack_w
      assign flat_o[WIDE_BASE + g*2*BYTE_W +: 2*BYTE_W] = wid[g];
   end
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
   import sbus_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit RSVD_ZERO   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sclk,
   input  logic               bus_csn,
   input  logic               bus_cmd,
   output logic               bus_reply,
   output logic               bus_reply_oe,
   input  logic [BYTE_W-1:0]  status_byte,
   input  logic [BYTE_W-1:0]  flag_byte,
   output logic [FLAT_W-1:0]  regs_flat
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sbus_slave: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("sbus_slave: command decode assumes 8-bit bytes");
   end

   logic                 sclk_s, csn_s, din_s;
   logic                 wr_en, wr_wide, clr, fall_p;
   logic [BYTE_W-1:0]    wr_addr;
   logic [2*BYTE_W-1:0]  wr_data;

   sbus_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bus_sclk, bus_csn, bus_cmd}),
      .q_o   ({sclk_s, csn_s, din_s})
   );

   sbus_frame u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sclk_s),
      .csn_s      (csn_s),
      .din_s      (din_s),
      .stat_i     (status_byte),
      .flag_i     (flag_byte),
      .wr_en_o    (wr_en),
      .wr_wide_o  (wr_wide),
      .wr_addr_o  (wr_addr),
      .wr_data_o  (wr_data),
      .clr_o      (clr),
      .fall_o     (fall_p),
      .reply_o    (bus_reply),
      .reply_oe_o (bus_reply_oe)
   );

   sbus_regs #(
      .RSVD_ZERO (RSVD_ZERO)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .wr_en_i   (wr_en),
      .wr_wide_i (wr_wide),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .flat_o    (regs_flat)
   );
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk
   import sbus_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               csn_s,
   input logic               fall_p,
   input logic               reply,
   input logic               reply_oe,
   input logic               clr,
   input logic               wr_en,
   input logic [FLAT_W-1:0]  regs
);
   AST_OE_OFF_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !reply_oe);                                               // R10
   AST_REPLY_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fall_p) |-> $stable(reply));                                 // R9
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (regs == '0));                                              // R6
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$past(clr)) |-> $stable(regs));                  // R8
   AST_SIGCTL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[4] == 1'b0) && (regs[3] == 1'b0) && (regs[1] == 1'b0));       // R7
endmodule

bind sbus_slave sbus_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csn_s    (csn_s),
   .fall_p   (fall_p),
   .reply    (bus_reply),
   .reply_oe (bus_reply_oe),
   .clr      (clr),
   .wr_en    (wr_en),
   .regs     (regs_flat)
);

// File: tb/sbus_slave_tb.sv
module sbus_slave_tb;
   import sbus_pkg::*;

   localparam int HALF = 6;
   localparam int WD   = 200000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, bus_sclk, bus_csn, bus_cmd;
   logic              bus_reply, bus_reply_oe;
   logic [7:0]        status_byte, flag_byte;
   logic [FLAT_W-1:0] regs_flat;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0]  m8  [8];
   logic [15:0] m16 [4];

   sbus_slave u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sclk(bus_sclk), .bus_csn(bus_csn),
      .bus_cmd(bus_cmd), .bus_reply(bus_reply), .bus_reply_oe(bus_reply_oe),
      .status_byte(status_byte), .flag_byte(flag_byte), .regs_flat(regs_flat)
   );

   function automatic logic [FLAT_W-1:0] exp_flat();
      logic [FLAT_W-1:0] f;
      for (int i = 0; i < 8; i++) f[i*8 +: 8] = m8[i];
      for (int i = 0; i < 4; i++) f[64 + i*16 +: 16] = m16[i];
      return f;
   endfunction

   function automatic bit is_wide(input logic [7:0] a);
      return (a == 8'h83) || (a == 8'h84) || (a == 8'h8A) || (a == 8'h8D);
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 8; i++) m8[i] = '0;
      for (int i = 0; i < 4; i++) m16[i] = '0;
   endtask

   task automatic model_write(input logic [7:0] a, input logic [15:0] d);
      case (a)
         8'h01: model_clear();
         8'h80: m8[0] = d[7:0] & 8'hE5;
         8'h82: m8[1] = d[7:0];
         8'h85: m8[2] = d[7:0];
         8'h86: m8[3] = d[7:0];
         8'h87: m8[4] = d[7:0];
         8'h88: m8[5] = d[7:0];
         8'h8B: m8[6] = d[7:0];
         8'h8E: m8[7] = d[7:0];
         8'h83: m16[0] = d;
         8'h84: m16[1] = d;
         8'h8A: m16[2] = d;
         8'h8D: m16[3] = d;
         default: ;
      endcase
   endtask

   task automatic chk(input string tag, input logic [FLAT_W-1:0] act, input logic [FLAT_W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      bus_cmd = b;
      wait_n(HALF);
      bus_sclk = 1'b1;
      wait_n(HALF);
      bus_sclk = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
   endtask

   task automatic open_frame();
      bus_csn = 1'b0;
      wait_n(HALF);
   endtask

   task automatic close_frame();
      wait_n(HALF);
      bus_csn = 1'b1;
      wait_n(HALF + 4);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [15:0] d, input string tag);
      open_frame();
      put_byte(a);
      if (is_wide(a)) begin
         put_byte(d[15:8]);
         put_byte(d[7:0]);
      end else if (a != 8'h01) begin
         put_byte(d[7:0]);
      end
      close_frame();
      model_write(a, d);
      chk(tag, regs_flat, exp_flat());
   endtask

   task automatic do_read(input logic [7:0] a, input logic [7:0] expv, input string tag);
      logic [7:0] got;
      logic oe_on, oe_after;
      oe_on = 1'b1;
      open_frame();
      put_byte(a);
      for (int i = 7; i >= 0; i--) begin
         wait_n(HALF);
         got[i] = bus_reply;
         oe_on  = oe_on & bus_reply_oe;
         bus_sclk = 1'b1;
         wait_n(HALF);
         bus_sclk = 1'b0;
      end
      wait_n(HALF);
      oe_after = bus_reply_oe;
      close_frame();
      chk({tag, " R9 reply byte"}, FLAT_W'(got), FLAT_W'(expv));
      chk("R10 oe during reply", FLAT_W'(oe_on), FLAT_W'(1));
      chk("R10 oe after 8th bit", FLAT_W'(oe_after), FLAT_W'(0));
      chk("R10 oe after frame", FLAT_W'(bus_reply_oe), FLAT_W'(0));
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] list [16];
      list = '{8'h80, 8'h82, 8'h85, 8'h86, 8'h87, 8'h88, 8'h8B, 8'h8E,
               8'h83, 8'h84, 8'h8A, 8'h8D, 8'h01, 8'h9C, 8'h81, 8'h8F};
      void'($urandom(32'd828));
      rst_n = 1'b0; bus_sclk = 1'b0; bus_csn = 1'b1; bus_cmd = 1'b0;
      status_byte = 8'h00; flag_byte = 8'h00;
      model_clear();
      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      chk("R1 registers after reset", regs_flat, '0);
      chk("R1 oe after reset", FLAT_W'(bus_reply_oe), FLAT_W'(0));

      // R2 every narrow register, distinct values
      do_write(8'h82, 16'h00A7, "R2 $82");
      do_write(8'h85, 16'h0031, "R2 $85");
      do_write(8'h86, 16'h00C4, "R2 $86");
      do_write(8'h87, 16'h005B, "R2 $87");
      do_write(8'h88, 16'h0096, "R2 $88");
      do_write(8'h8B, 16'h00F0, "R2 $8B");
      do_write(8'h8E, 16'h000F, "R2 $8E");
      // R3 every wide register
      do_write(8'h83, 16'h1234, "R3 $83");
      do_write(8'h84, 16'hBEEF, "R3 $84");
      do_write(8'h8A, 16'h3C5A, "R3 $8A");
      do_write(8'h8D, 16'h8001, "R3 $8D");
      // R7 reserved bits of control register
      do_write(8'h80, 16'h00FF, "R7 reserved bits read zero");
      do_write(8'h80, 16'h001A, "R7 only reserved bits set");
      // R8 unassigned commands
      do_write(8'h9C, 16'h0055, "R8 unknown $9C");
      open_frame(); put_byte(8'hC3); put_byte(8'hFF); put_byte(8'hFF); close_frame();
      chk("R8 unknown $C3 with two bytes", regs_flat, exp_flat());

      // R4 wide write aborted after first byte
      open_frame(); put_byte(8'h84); put_byte(8'h77); close_frame();
      chk("R4 wide register atomic", regs_flat, exp_flat());
      // R5 aborts mid-byte: data byte, then a clear command cut short
      open_frame(); put_byte(8'h82);
      for (int i = 0; i < 5; i++) put_bit(1'b1);
      close_frame();
      chk("R5 partial data byte", regs_flat, exp_flat());
      open_frame();
      for (int i = 0; i < 7; i++) put_bit(1'b0);
      close_frame();
      chk("R5 partial clear command", regs_flat, exp_flat());

      // R11 chip select release on the completing edge
      do_write(8'h88, 16'h0011, "R11 pre-write");
      open_frame(); put_byte(8'h88);
      for (int i = 7; i >= 1; i--) put_bit(1'b1);
      bus_cmd = 1'b1;
      wait_n(HALF);
      bus_sclk = 1'b1;
      bus_csn  = 1'b1;
      wait_n(HALF);
      bus_sclk = 1'b0;
      wait_n(HALF + 4);
      chk("R11 coincident release discards byte", regs_flat, exp_flat());
      do_write(8'h88, 16'h0022, "R11 next frame clean");

      // R12 trailing bytes ignored
      open_frame(); put_byte(8'h86); put_byte(8'h3C); put_byte(8'hC3); put_byte(8'h99); close_frame();
      model_write(8'h86, 16'h003C);
      chk("R12 trailing bytes ignored", regs_flat, exp_flat());
      open_frame(); put_byte(8'h8D); put_byte(8'hAB); put_byte(8'hCD); put_byte(8'hEF); close_frame();
      model_write(8'h8D, 16'hABCD);
      chk("R12 trailing byte after wide write", regs_flat, exp_flat());

      // R9 / R10 reads
      status_byte = 8'hA5; flag_byte = 8'h3E;
      do_read(8'h81, 8'hA5, "status");
      do_read(8'h8F, 8'h3E, "flags");
      chk("R9 read leaves registers", regs_flat, exp_flat());

      // R6 clear command
      do_write(8'h01, 16'h0000, "R6 clear command");
      chk("R6 all zero", regs_flat, '0);

      // mixed random traffic
      for (int t = 0; t < 60; t++) begin
         logic [7:0] a;
         logic [15:0] d;
         a = list[$urandom_range(15, 0)];
         d = 16'($urandom);
         if (a == 8'h81 || a == 8'h8F) begin
            status_byte = 8'($urandom);
            flag_byte   = 8'($urandom);
            do_read(a, (a == 8'h81) ? status_byte : flag_byte, "random");
         end else if (a == 8'h01) begin
            do_write(a, d, "R6 random clear");
         end else if (is_wide(a)) begin
            do_write(a, d, "R3 random wide");
         end else if (a == 8'h9C) begin
            do_write(a, d, "R8 random unknown");
         end else begin
            do_write(a, d, "R2 random narrow");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule